// File: doc/BRIEF.md
# Little-Endian Multi-Width Load Aligner

This block is the data-return stage of a load unit in a byte-addressable machine with 32-bit addresses. A load request carries an address, a size code, an unsigned flag and a destination register tag. The memory side presents two consecutive 64-bit lines. The low line holds the eight bytes starting at the address with its three low bits cleared. The high line holds the eight bytes after those. The aligner picks the requested bytes out of this 16-byte window in little-endian order, right-justifies them and extends them to the 32-bit register width.

A doubleword comes back as a pair of 32-bit results for an even/odd register pair. The 16-byte window lets a doubleword start on any 4-byte boundary. Halfwords and words must be naturally aligned. A badly aligned request raises an error flag in place of data. The response is registered and appears one cycle after the request, together with the tag.

Top module: `load_align_top`

## Requirements
- R1: Byte k of the window is `mem_line_lo[8k+7:8k]` for k = 0..7 and `mem_line_hi[8(k-8)+7:8(k-8)]` for k = 8..15. A load reads consecutive window bytes starting at index `req_addr[2:0]`, and the lowest-addressed byte lands in bits 7:0 of the result (little-endian).
- R2: `req_size` encodes 0 = byte (1 byte), 1 = halfword (2 bytes), 2 = word (4 bytes), 3 = doubleword (8 bytes).
- R3: For a byte or halfword load, `rsp_lo` is sign-extended from the top loaded bit when `req_unsigned` = 0 and zero-extended when it is 1. A word load is the same for either flag value.
- R4: A doubleword load puts window bits 31:0 of the loaded value on `rsp_lo` (even register) and bits 63:32 on `rsp_hi` (odd register).
- R5: For any size other than doubleword, `rsp_hi` is zero.
- R6: A halfword with `req_addr[0]` = 1, or a word or doubleword with `req_addr[1:0]` != 0, sets `rsp_misalign`, and `rsp_lo` and `rsp_hi` are then zero. A byte load never sets it.
- R7: `rsp_valid` rises in the cycle after a request with `req_valid` = 1, and `rsp_tag` then equals that request's `req_tag`.
- R8: In a cycle after one with `req_valid` = 0, `rsp_valid`, `rsp_misalign`, `rsp_tag`, `rsp_lo` and `rsp_hi` are all zero.
- R9: While `rst_n` is low, all response outputs are zero.
- R10: With bytes 0x01..0x08 at addresses 4..11 and address 4, a byte load returns 0x00000001, a halfword load returns 0x00000201, and a doubleword load returns hi 0x08070605 and lo 0x04030201.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present this cycle |
| req_addr | input | ADDR_W | Byte address of the load |
| req_size | input | 2 | Size code (R2) |
| req_unsigned | input | 1 | 1 = zero-extend, 0 = sign-extend |
| req_tag | input | TAG_W | Destination register tag |
| mem_line_lo | input | 64 | Line at the address with its low three bits cleared |
| mem_line_hi | input | 64 | Following 64-bit line |
| rsp_valid | output | 1 | Response valid |
| rsp_misalign | output | 1 | Alignment error for this response |
| rsp_tag | output | TAG_W | Tag returned with the response |
| rsp_lo | output | 32 | Result, or even register of a pair |
| rsp_hi | output | 32 | Odd register of a pair, zero otherwise |

## Verification
The assertions assume that both memory lines are valid in the same cycle as `req_valid`. They also assume that `req_size` always holds one of the four defined codes, which is true of any 2-bit value, so every input pattern is legal. The stimulus drives random addresses, sizes, flags and line contents, with idle gaps between requests. It adds directed cases at every offset of the window, so both aligned and misaligned requests reach the checks.

// File: rtl/la_pkg.sv
package la_pkg;
  localparam int LINE_W     = 64;
  localparam int REG_W      = 32;
  localparam int LINE_BYTES = LINE_W / 8;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int WIN_W      = 2 * LINE_W;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } size_e;

  // Bytes from offset onward, lowest address at bit 0.
  function automatic logic [LINE_W-1:0] win_pick(input logic [WIN_W-1:0] win,
                                                 input logic [OFF_W-1:0] off);
    logic [WIN_W-1:0] sh;
    sh = win >> {off, 3'b000};
    return sh[LINE_W-1:0];
  endfunction

  // Halfword needs bit 0 clear, word and doubleword need bits 1:0 clear.
  function automatic logic is_misaligned(input size_e sz, input logic [OFF_W-1:0] off);
    case (sz)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return off[0];
      default: return |off[1:0];
    endcase
  endfunction
endpackage

// File: rtl/la_window.sv
module la_window
  import la_pkg::*;
(
  input  logic [LINE_W-1:0] line_lo,
  input  logic [LINE_W-1:0] line_hi,
  input  logic [OFF_W-1:0]  offset,
  output logic [LINE_W-1:0] raw
);
  logic [WIN_W-1:0] window;
  assign window = {line_hi, line_lo};
  assign raw    = win_pick(window, offset);
endmodule

// File: rtl/la_misalign.sv
module la_misalign
  import la_pkg::*;
(
  input  size_e            size,
  input  logic [OFF_W-1:0] offset,
  output logic             bad
);
  assign bad = is_misaligned(size, offset);
endmodule

// File: rtl/la_extend.sv
module la_extend
  import la_pkg::*;
(
  input  logic [LINE_W-1:0] raw,
  input  size_e             size,
  input  logic              unsigned_ld,
  output logic [REG_W-1:0]  res_lo,
  output logic [REG_W-1:0]  res_hi
);
  logic fill_b, fill_h;
  assign fill_b = ~unsigned_ld & raw[7];
  assign fill_h = ~unsigned_ld & raw[15];

  always_comb begin
    res_hi = '0;
    case (size)
      SZ_BYTE: res_lo = {{(REG_W-8){fill_b}}, raw[7:0]};
      SZ_HALF: res_lo = {{(REG_W-16){fill_h}}, raw[15:0]};
      SZ_WORD: res_lo = raw[REG_W-1:0];
      default: begin
        res_lo = raw[REG_W-1:0];
        res_hi = raw[LINE_W-1:REG_W];
      end
    endcase
  end
endmodule

// File: rtl/load_align_top.sv
module load_align_top
  import la_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_unsigned,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [63:0]       mem_line_lo,
  input  logic [63:0]       mem_line_hi,
  output logic              rsp_valid,
  output logic              rsp_misalign,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [31:0]       rsp_lo,
  output logic [31:0]       rsp_hi
);
  size_e            size_w;
  logic [OFF_W-1:0] off_w;
  logic [LINE_W-1:0] raw_w;
  logic             mis_w;
  logic [REG_W-1:0] ext_lo_w, ext_hi_w;

  assign size_w = size_e'(req_size);
  assign off_w  = req_addr[OFF_W-1:0];

  la_window u_win (
    .line_lo(mem_line_lo), .line_hi(mem_line_hi), .offset(off_w), .raw(raw_w)
  );

  la_misalign u_mis (
    .size(size_w), .offset(off_w), .bad(mis_w)
  );

  la_extend u_ext (
    .raw(raw_w), .size(size_w), .unsigned_ld(req_unsigned),
    .res_lo(ext_lo_w), .res_hi(ext_hi_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_misalign <= 1'b0;
      rsp_tag      <= '0;
      rsp_lo       <= '0;
      rsp_hi       <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_misalign <= mis_w;
        rsp_tag      <= req_tag;
        rsp_lo       <= mis_w ? '0 : ext_lo_w;
        rsp_hi       <= mis_w ? '0 : ext_hi_w;
      end else begin
        rsp_misalign <= 1'b0;
        rsp_tag      <= '0;
        rsp_lo       <= '0;
        rsp_hi       <= '0;
      end
    end
  end

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid) else $error("valid latency");                    // R7
  AST_TAG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_tag == $past(req_tag)) else $error("tag");              // R7
  AST_MIS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_misalign |-> (rsp_lo == '0 && rsp_hi == '0)) else $error("mis data"); // R6
  AST_BYTE_NO_MIS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd0) |=> !rsp_misalign) else $error("byte");   // R6
  AST_NARROW_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != 2'd3) |=> rsp_hi == '0) else $error("hi");      // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_misalign && rsp_lo == '0 && rsp_hi == '0
                    && rsp_tag == '0)) else $error("idle");                   // R8
endmodule

// File: tb/load_align_top_test.sv
`timescale 1ns/1ps
module load_align_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_unsigned = 1'b0;
  logic [4:0]  req_tag = '0;
  logic [63:0] mem_line_lo = '0, mem_line_hi = '0;
  logic        rsp_valid, rsp_misalign;
  logic [4:0]  rsp_tag;
  logic [31:0] rsp_lo, rsp_hi;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  load_align_top uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_tag(req_tag),
    .mem_line_lo(mem_line_lo), .mem_line_hi(mem_line_hi),
    .rsp_valid(rsp_valid), .rsp_misalign(rsp_misalign), .rsp_tag(rsp_tag),
    .rsp_lo(rsp_lo), .rsp_hi(rsp_hi)
  );

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Behavioural model built from the requirements.
  task automatic model(input bit v, input logic [31:0] a, input int s, input bit u,
                       input logic [63:0] l, input logic [63:0] h,
                       output bit em, output logic [31:0] elo, output logic [31:0] ehi);
    byte unsigned w[16];
    int n, al, off;
    longint unsigned val;
    for (int i = 0; i < 8; i++) begin
      w[i]   = l[8*i +: 8];
      w[i+8] = h[8*i +: 8];
    end
    n   = 1 << s;
    al  = (s == 3) ? 4 : n;
    off = int'(a % 8);
    em  = v && (a % al != 0);
    val = 0;
    for (int k = 0; k < n; k++) val = val | (longint'(w[off+k]) << (8*k));
    elo = '0; ehi = '0;
    if (v && !em) begin
      if (s == 3) begin
        elo = val[31:0];
        ehi = val[63:32];
      end else begin
        elo = val[31:0];
        if (s < 2 && !u && val[8*n-1]) elo = elo | (32'hFFFF_FFFF << (8*n));
      end
    end
  endtask

  task automatic step(input string req, input bit v, input logic [31:0] a, input int s,
                      input bit u, input logic [4:0] t,
                      input logic [63:0] l, input logic [63:0] h);
    bit em;
    logic [31:0] elo, ehi;
    @(negedge clk);
    req_valid = v; req_addr = a; req_size = 2'(s); req_unsigned = u;
    req_tag = t; mem_line_lo = l; mem_line_hi = h;
    model(v, a, s, u, l, h, em, elo, ehi);
    @(posedge clk); #1;
    chk(req, "valid (R7)", rsp_valid, v);
    chk(req, "tag (R7)", rsp_tag, v ? t : 5'd0);
    chk(req, "misalign (R6)", rsp_misalign, em);
    chk(req, "lo", rsp_lo, elo);
    chk(req, "hi", rsp_hi, ehi);
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [63:0] L_EX = 64'h0403_0201_0D0C_0B0A;
  localparam logic [63:0] H_EX = 64'h0000_0000_0807_0605;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "reset valid", rsp_valid, 0);
    chk("R9", "reset lo", rsp_lo, 0);
    chk("R9", "reset hi", rsp_hi, 0);
    chk("R9", "reset tag", rsp_tag, 0);
    @(negedge clk); rst_n = 1'b1;

    // R10 example: bytes 1..8 at 4..11
    step("R10", 1, 32'h4, 0, 0, 5'd7, L_EX, H_EX);
    chk("R10", "byte", rsp_lo, 32'h0000_0001);
    step("R10", 1, 32'h4, 1, 0, 5'd8, L_EX, H_EX);
    chk("R10", "half", rsp_lo, 32'h0000_0201);
    step("R10", 1, 32'h4, 3, 0, 5'd9, L_EX, H_EX);
    chk("R10 R4", "dword lo", rsp_lo, 32'h0403_0201);
    chk("R10 R4", "dword hi", rsp_hi, 32'h0807_0605);
    step("R1", 1, 32'h4, 2, 0, 5'd1, L_EX, H_EX);
    chk("R1 R2", "word", rsp_lo, 32'h0403_0201);

    // R3 sign versus zero extension
    step("R3", 1, 32'h1000_0003, 0, 0, 5'd2, 64'h0000_0000_8000_0000, '0);
    chk("R3", "signed byte", rsp_lo, 32'hFFFF_FF80);
    step("R3", 1, 32'h1000_0003, 0, 1, 5'd2, 64'h0000_0000_8000_0000, '0);
    chk("R3", "unsigned byte", rsp_lo, 32'h0000_0080);
    step("R3", 1, 32'h6, 1, 0, 5'd3, 64'hF00D_0000_0000_0000, '0);
    chk("R3", "signed half", rsp_lo, 32'hFFFF_F00D);
    step("R3", 1, 32'h6, 1, 1, 5'd3, 64'hF00D_0000_0000_0000, '0);
    chk("R3", "unsigned half", rsp_lo, 32'h0000_F00D);
    step("R3", 1, 32'h0, 2, 1, 5'd3, 64'h0000_0000_8765_4321, '0);
    chk("R3", "word flag ignored", rsp_lo, 32'h8765_4321);

    // R6 misaligned requests
    step("R6", 1, 32'h5, 1, 0, 5'd4, L_EX, H_EX);
    chk("R6", "half odd", rsp_misalign, 1);
    step("R6", 1, 32'h6, 2, 0, 5'd4, L_EX, H_EX);
    chk("R6", "word off2", rsp_misalign, 1);
    step("R6", 1, 32'h2, 3, 0, 5'd4, L_EX, H_EX);
    chk("R6", "dword off2", rsp_hi, 0);
    step("R6", 1, 32'h7, 0, 0, 5'd4, L_EX, H_EX);
    chk("R6", "byte never", rsp_misalign, 0);

    // R8 idle after traffic, R5 narrow hi
    step("R8", 0, 32'h4, 3, 0, 5'd31, L_EX, H_EX);
    chk("R8", "idle lo", rsp_lo, 0);
    step("R5", 1, 32'h7, 0, 0, 5'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R5", "byte hi", rsp_hi, 0);

    // R1 every offset, every size
    for (int o = 0; o < 8; o++)
      for (int s = 0; s < 4; s++)
        step("R1", 1, 32'h2000 + 32'(o), s, 0, 5'(o), 64'h1716_1514_1312_1110,
             64'h1F1E_1D1C_1B1A_1918);

    // random traffic with idle gaps
    for (int i = 0; i < 400; i++)
      step("R1-rand", ($urandom % 4) != 0, $urandom, int'($urandom % 4), $urandom % 2,
           5'($urandom), {$urandom, $urandom}, {$urandom, $urandom});

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule